// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

A synchronous twisted-ring counter of `STAGES` flip-flops (at least three). On each enabled clock edge the word shifts one place toward its high end. Bit 0 takes the inverse of the top bit, so the word first fills with ones and then drains to zeros. The legal cycle therefore has `2*STAGES` states. Any two neighbouring states in it differ in a single bit, which makes a two-input decode of each state free of glitches.

A plain twisted ring has `2^STAGES - 2*STAGES` unused patterns. Once the counter falls into one of them, it circulates among them for ever. In this block, a legality detector watches the stored word. When an enabled edge finds an illegal pattern, the next state is forced to all zeros, so the counter rejoins the legal cycle on that one edge. A preset port can write any pattern, illegal ones included. This lets the recovery path be exercised directly.

There is one strobe per legal state. Each strobe is the AND of two adjacent state bits, qualified by the legality flag, so no strobe fires while the word is illegal.

Top module: `twisted_ring_counter`

## Requirements
- R1: A high `rst` at a rising edge sets every bit of `ring_q` to 0, and after that edge `phase_hit` has only bit 0 set.
- R2: On an enabled edge from a legal state, bit 0 of `ring_q` takes the inverse of bit `STAGES-1`, and bit i takes the old bit i-1. For `STAGES=4`, `ring_q` (written bit3..bit0) steps 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and then back to 0000.
- R3: With `count_en` low, and neither `rst` nor `preset_load` high, `ring_q` and `phase_hit` keep their values across the edge. This holds for illegal patterns too.
- R4: Priority at an edge is `rst` first, then `preset_load`, then `count_en`.
- R5: A high `preset_load` copies `preset_value` into `ring_q` at the edge, whatever the pattern and whatever the level of `count_en`.
- R6: In a legal state, exactly one bit k of `phase_hit` is set. The value of k is:
  - 0 for the all-zero word;
  - the number of ones when bit 0 is 1;
  - `2*STAGES` minus the number of ones otherwise.
- R7: In an illegal state, `phase_hit` is all zeros.
- R8: An enabled edge taken from an illegal state loads all zeros. The counter is therefore back in the legal cycle after one edge, which is well inside the bound of `STAGES` edges.
- R9: Across enabled edges from a legal state, successive words differ in exactly one bit. The counter returns to all zeros after exactly `2*STAGES` edges, and not before.
- R10: A pattern is legal if and only if at most one position i in 0..`STAGES-2` has bit i different from bit i+1. This gives exactly `2*STAGES` legal patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Advance enable |
| preset_load | input | 1 | Writes `preset_value` into the state |
| preset_value | input | STAGES | Pattern written by a preset |
| ring_q | output | STAGES | Stored state, bit 0 is the first stage |
| phase_hit | output | 2*STAGES | One strobe per legal state, all low when illegal |

## Verification
Every change of `ring_q` appears one rising edge after the inputs that cause it. `phase_hit` is combinational from the stored word, so it is due in the same cycle as the new state. This applies to reset, preset, hold, advance and repair alike. The bench drives its inputs on a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. The repair check therefore expects all zeros at the first sample after an enabled step from an illegal preset. The period check counts sampled steps until the zero word reappears.

// File: rtl/twr_pkg.sv
package twr_pkg;

    // Action chosen for the next edge (reset is applied in the register itself)
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_SHIFT  = 2'd1,
        STEP_REPAIR = 2'd2,
        STEP_PRESET = 2'd3
    } step_e;

    typedef struct packed {
        logic load;
        logic en;
    } ctrl_t;

    // Preset beats enable; an enabled illegal word is repaired, not shifted
    function automatic step_e pick_step(input ctrl_t c, input logic legal);
        step_e s;
        if (c.load)
            s = STEP_PRESET;
        else if (!c.en)
            s = STEP_HOLD;
        else if (legal)
            s = STEP_SHIFT;
        else
            s = STEP_REPAIR;
        return s;
    endfunction

endpackage

// File: rtl/twr_legal_check.sv
module twr_legal_check #(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] q,
    output logic              legal
);
    localparam int EDGES = STAGES - 1;

    logic [EDGES-1:0] diff;

    // One flag per pair of neighbouring stages that disagree
    for (genvar i = 0; i < EDGES; i++) begin : g_diff
        assign diff[i] = q[i] ^ q[i+1];
    end

    // Legal iff at most one disagreement: clearing the lowest set bit leaves zero
    assign legal = ((diff & (diff - {{(EDGES-1){1'b0}}, 1'b1})) == '0);

endmodule

// File: rtl/twr_next_state.sv
module twr_next_state
    import twr_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] q,
    input  step_e             step,
    input  logic [STAGES-1:0] preset,
    output logic [STAGES-1:0] nxt
);
    always_comb begin
        case (step)
            STEP_SHIFT:  nxt = {q[STAGES-2:0], ~q[STAGES-1]};
            STEP_REPAIR: nxt = '0;
            STEP_PRESET: nxt = preset;
            default:     nxt = q;
        endcase
    end

endmodule

// File: rtl/twr_phase_decode.sv
module twr_phase_decode #(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0]   q,
    input  logic                legal,
    output logic [2*STAGES-1:0] hit
);
    localparam int PHASES = 2 * STAGES;

    logic [PHASES-1:0] raw;

    // Each phase is identified by one pair of adjacent stage bits
    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        if (k == 0) begin : g_empty
            assign raw[k] = ~q[0] & ~q[STAGES-1];
        end else if (k < STAGES) begin : g_fill
            assign raw[k] = q[k-1] & ~q[k];
        end else if (k == STAGES) begin : g_full
            assign raw[k] = q[0] & q[STAGES-1];
        end else begin : g_drain
            assign raw[k] = ~q[k-STAGES-1] & q[k-STAGES];
        end
    end

    assign hit = legal ? raw : '0;

endmodule

// File: rtl/twisted_ring_counter.sv
module twisted_ring_counter
    import twr_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                count_en,
    input  logic                preset_load,
    input  logic [STAGES-1:0]   preset_value,
    output logic [STAGES-1:0]   ring_q,
    output logic [2*STAGES-1:0] phase_hit
);
    logic              legal;
    step_e             step;
    ctrl_t             ctrl;
    logic [STAGES-1:0] nxt;

    twr_legal_check #(.STAGES(STAGES)) u_legal (
        .q     (ring_q),
        .legal (legal)
    );

    assign ctrl = '{load: preset_load, en: count_en};
    assign step = pick_step(ctrl, legal);

    twr_next_state #(.STAGES(STAGES)) u_next (
        .q      (ring_q),
        .step   (step),
        .preset (preset_value),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ring_q <= '0;
        else
            ring_q <= nxt;
    end

    twr_phase_decode #(.STAGES(STAGES)) u_decode (
        .q     (ring_q),
        .legal (legal),
        .hit   (phase_hit)
    );

endmodule

// File: rtl/twr_ring_checker.sv
module twr_ring_checker #(
    parameter int STAGES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                count_en,
    input logic                preset_load,
    input logic [STAGES-1:0]   preset_value,
    input logic [STAGES-1:0]   ring_q,
    input logic [2*STAGES-1:0] phase_hit
);
    localparam int PH = 2 * STAGES;

    logic ok;
    assign ok = ($countones(ring_q[STAGES-2:0] ^ ring_q[STAGES-1:1]) <= 1);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ring_q == '0 && phase_hit[0])); // R1

    AST_PHASE_ROTATES: assert property (@(posedge clk) disable iff (rst)
        (!preset_load && count_en && ok) |=>
        phase_hit == {$past(phase_hit[PH-2:0]), $past(phase_hit[PH-1])}); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!preset_load && !count_en) |=> $stable(ring_q)); // R3

    AST_PRESET_TAKES: assert property (@(posedge clk) disable iff (rst)
        preset_load |=> ring_q == $past(preset_value)); // R5

    AST_HIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ok |-> $countones(phase_hit) == 1); // R6

    AST_HIT_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        !ok |-> phase_hit == '0); // R7

    AST_REPAIR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!preset_load && count_en && !ok) |=> ring_q == '0); // R8

    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        (!preset_load && count_en && ok) |=>
        $countones(ring_q ^ $past(ring_q)) == 1); // R9

endmodule

bind twisted_ring_counter twr_ring_checker #(.STAGES(STAGES)) u_ring_checker (.*);

// File: tb/test_twisted_ring_counter.sv
module test_twisted_ring_counter;
    localparam int N  = 4;
    localparam int PH = 2 * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          count_en = 1'b0;
    logic          preset_load = 1'b0;
    logic [N-1:0]  preset_value = '0;
    logic [N-1:0]  ring_q;
    logic [PH-1:0] phase_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    twisted_ring_counter #(.STAGES(N)) i_twisted_ring_counter (
        .clk          (clk),
        .rst          (rst),
        .count_en     (count_en),
        .preset_load  (preset_load),
        .preset_value (preset_value),
        .ring_q       (ring_q),
        .phase_hit    (phase_hit)
    );

    // Row fields {rst, en, load, value[3:0], expected ring_q[3:0]}
    localparam int ROWS = 15;
    localparam logic [10:0] VEC [ROWS] = '{
        {3'b100, 4'b0000, 4'b0000},  // R1 reset
        {3'b010, 4'b0000, 4'b0001},  // R2
        {3'b010, 4'b0000, 4'b0011},  // R2
        {3'b000, 4'b0000, 4'b0011},  // R3 hold
        {3'b010, 4'b0000, 4'b0111},  // R2
        {3'b010, 4'b0000, 4'b1111},  // R2
        {3'b010, 4'b0000, 4'b1110},  // R2
        {3'b010, 4'b0000, 4'b1100},  // R2
        {3'b010, 4'b0000, 4'b1000},  // R2
        {3'b010, 4'b0000, 4'b0000},  // R2 wrap
        {3'b001, 4'b1100, 4'b1100},  // R5 legal preset
        {3'b010, 4'b0000, 4'b1000},  // R2
        {3'b111, 4'b0101, 4'b0000},  // R4 reset over all
        {3'b011, 4'b0111, 4'b0111},  // R4 preset over enable
        {3'b010, 4'b0000, 4'b1111}   // R2
    };
    localparam int VREQ [ROWS] = '{1, 2, 2, 3, 2, 2, 2, 2, 2, 2, 5, 2, 4, 4, 2};

    function automatic bit exp_legal(input logic [N-1:0] q);
        int d = 0;
        for (int i = 0; i < N - 1; i++)
            if (q[i] != q[i+1]) d++;
        return d <= 1;
    endfunction

    function automatic logic [PH-1:0] exp_hit(input logic [N-1:0] q);
        int ones = $countones(q);
        int p;
        if (!exp_legal(q)) return '0;
        if (q[0])           p = ones;
        else if (ones == 0) p = 0;
        else                p = PH - ones;
        return PH'(1) << p;
    endfunction

    task automatic step(input logic r, input logic e, input logic l, input logic [N-1:0] v);
        rst = r; count_en = e; preset_load = l; preset_value = v;
        @(negedge clk);
    endtask

    task automatic check_q(input string tag, input logic [N-1:0] exp);
        checks++;
        if (ring_q !== exp) begin
            fails++;
            $display("FAIL %s: ring_q=%b expected %b", tag, ring_q, exp);
        end
    endtask

    task automatic check_hit(input string tag, input logic [N-1:0] q);
        checks++;
        if (phase_hit !== exp_hit(q)) begin
            fails++;
            $display("FAIL %s: phase_hit=%b expected %b", tag, phase_hit, exp_hit(q));
        end
    endtask

    task automatic check_bool(input string tag, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        @(negedge clk);

        // Vector table: one edge per row, sampled at the next falling edge
        for (int r = 0; r < ROWS; r++) begin
            step(VEC[r][10], VEC[r][9], VEC[r][8], VEC[r][7:4]);
            check_q($sformatf("R%0d row %0d", VREQ[r], r), VEC[r][3:0]);
            check_hit($sformatf("R6 row %0d", r), VEC[r][3:0]);
        end

        // R3 / R7: an illegal word held with enable low
        step(0, 0, 1, 4'b0101);
        check_q("R5 illegal preset", 4'b0101);
        check_hit("R7 illegal preset", 4'b0101);
        step(0, 0, 0, 4'b0000);
        check_q("R3 illegal hold", 4'b0101);
        check_hit("R7 illegal hold", 4'b0101);

        // R4: reset beats preset while illegal
        step(1, 1, 1, 4'b1010);
        check_q("R4 reset over preset", 4'b0000);
        check_hit("R1 strobe after reset", 4'b0000);

        // R8 / R9: every illegal pattern repaired, then a clean period of 2N
        for (int p = 0; p < (1 << N); p++) begin
            if (!exp_legal(N'(p))) begin
                step(0, 0, 1, N'(p));
                check_q("R5 preset illegal", N'(p));
                check_hit("R7 strobes low", N'(p));
                step(0, 1, 0, '0);
                check_q("R8 repair to zero", '0);
                check_hit("R6 after repair", '0);
                for (int s = 1; s <= PH; s++) begin
                    logic [N-1:0] prev;
                    prev = ring_q;
                    step(0, 1, 0, '0);
                    check_bool("R9 one-bit step", $countones(prev ^ ring_q) == 1, 1'b1);
                    check_bool("R9 period", ring_q == '0, s == PH);
                    check_hit("R6 ring strobe", ring_q);
                end
            end
        end

        // R10: legality of every pattern seen through the strobes
        for (int p = 0; p < (1 << N); p++) begin
            step(0, 0, 1, N'(p));
            check_bool("R10 legality", phase_hit != '0, exp_legal(N'(p)));
            check_hit("R10 strobe map", N'(p));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule